// File: doc/BRIEF.md
# Multi-User Interprocessor Mailbox Controller

This block lets several processors ("users") pass 32-bit messages to each other through a bank of small hardware FIFOs behind a plain register bus. A sender writes a word to a FIFO's message port and the receiver reads it back from the same port in arrival order. The receiver can also poll a per-FIFO full flag and a per-FIFO message count. Each FIFO raises two events: "holds a message" and "has room". Every user has its own sticky status register for these events, its own enable mask and its own interrupt line, so any user can be woken by any FIFO.

Two layouts of the per-user interrupt registers are available through a parameter. In the shared-enable layout, one enable register is read and written whole. In the split-enable layout, separate set and clear registers update the mask. The number of FIFOs, the number of users, the FIFO depth and the layout are all parameters.

Bus reads are registered. The data for a read strobe appears on `bus_rdata` after the clock edge that samples the strobe, and it holds until the next read.

Top module: `ipc_mailbox`

## Requirements
- R1: A read of offset 0x000 returns the constant given by parameter REV_ID.
- R2: A write to offset 0x040+4*m appends the word to FIFO m. A read of that offset pops and returns the oldest word. FIFOs are independent, and each holds FIFO_DEPTH words.
- R3: A write to a full FIFO is dropped. The stored words and the count are unchanged.
- R4: A read of an empty FIFO's message port returns zero and leaves the count at zero.
- R5: Offset 0x080+4*m reads 1 while FIFO m is full and 0 otherwise.
- R6: Offset 0x0C0+4*m reads the number of unread words in FIFO m, and reads zero when the FIFO is empty.
- R7: In every user's status register, bit 2*m is set on each cycle that FIFO m is non-empty, and bit 2*m+1 is set on each cycle that it is not full. A set bit stays set until it is cleared.
- R8: Writing 1 to a status bit clears it. When the event is present in the same cycle, the set wins, so the bit stays 1 while its condition holds.
- R9: Interrupt line u is high exactly when the status of user u ANDed with the enable mask of user u is nonzero.
- R10: Shared-enable layout: the status of user u is at 0x100+8*u and its enable mask is at 0x104+8*u. A write replaces the whole mask.
- R11: Split-enable layout: the status of user u is at 0x104+0x10*u, the set register at 0x108+0x10*u and the clear register at 0x10C+0x10*u. A write to the set register ORs its bits into the mask, and a write to the clear register removes its bits. A read of either register returns the mask.
- R12: Reset empties the FIFOs and zeroes every register and output. Read data changes only after a read strobe, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops when aimed at a message port) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
A software clear of a status bit and the hardware re-assertion of that same bit can fall into one clock cycle. The bench provokes this by clearing a new-message bit while its FIFO still holds a word. It also clears a not-full bit while its FIFO has room. It judges the result by reading the bit back: it must still be 1. It repeats the clear after the FIFO is drained, or after the FIFO has filled, and then expects 0. The bits of other users are read as well, to show that one user's clear leaves their sticky copies untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic {
      LAYOUT_SHARED_EN = 1'b0,
      LAYOUT_SPLIT_EN  = 1'b1
   } irq_layout_e;

   localparam int REV_OFF   = 'h000;
   localparam int MSG_BASE  = 'h040;
   localparam int FULL_BASE = 'h080;
   localparam int CNT_BASE  = 'h0C0;
   localparam int IRQ_BASE  = 'h100;
   localparam int MAX_FIFOS = 16;

   function automatic int fifo_off(input int base, input int idx);
      return base + 4 * idx;
   endfunction

   function automatic int sts_off(input irq_layout_e lay, input int u);
      return (lay == LAYOUT_SHARED_EN) ? IRQ_BASE + 8 * u : IRQ_BASE + 4 + 16 * u;
   endfunction

   function automatic int en_off(input irq_layout_e lay, input int u);
      return (lay == LAYOUT_SHARED_EN) ? IRQ_BASE + 4 + 8 * u : IRQ_BASE + 8 + 16 * u;
   endfunction

   function automatic int clr_off(input int u);
      return IRQ_BASE + 12 + 16 * u;
   endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("mbx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
   logic              do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = empty ? '0 : mem_q[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count    <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (do_push) begin
            mem_q[wr_ptr_q] <= wdata;
            wr_ptr_q        <= wr_ptr_q + 1'b1;
         end
         if (do_pop) rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R2: occupancy never exceeds the storage
   a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R3: a push into a full FIFO leaves it full
   a_r3_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == CNT_W'(DEPTH)));

   // R4: popping an empty FIFO leaves it empty
   a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/mbx_decode.sv
module mbx_decode #(
   parameter int                   NUM_FIFOS = 4,
   parameter int                   NUM_USERS = 2,
   parameter int                   ADDR_W    = 12,
   parameter mbx_pkg::irq_layout_e LAYOUT    = mbx_pkg::LAYOUT_SHARED_EN
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic                 rev_hit,
   output logic [NUM_FIFOS-1:0] msg_hit,
   output logic [NUM_FIFOS-1:0] full_hit,
   output logic [NUM_FIFOS-1:0] cnt_hit,
   output logic [NUM_USERS-1:0] sts_hit,
   output logic [NUM_USERS-1:0] en_hit,
   output logic [NUM_USERS-1:0] clr_hit
);

   assign rev_hit = (addr == ADDR_W'(mbx_pkg::REV_OFF));

   for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
      assign msg_hit[m]  = (addr == ADDR_W'(mbx_pkg::fifo_off(mbx_pkg::MSG_BASE, m)));
      assign full_hit[m] = (addr == ADDR_W'(mbx_pkg::fifo_off(mbx_pkg::FULL_BASE, m)));
      assign cnt_hit[m]  = (addr == ADDR_W'(mbx_pkg::fifo_off(mbx_pkg::CNT_BASE, m)));
   end

   for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
      assign sts_hit[u] = (addr == ADDR_W'(mbx_pkg::sts_off(LAYOUT, u)));
      assign en_hit[u]  = (addr == ADDR_W'(mbx_pkg::en_off(LAYOUT, u)));
      if (LAYOUT == mbx_pkg::LAYOUT_SPLIT_EN) begin : g_clr
         assign clr_hit[u] = (addr == ADDR_W'(mbx_pkg::clr_off(u)));
      end else begin : g_noclr
         assign clr_hit[u] = 1'b0;
      end
   end

endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
   parameter int                   EV_W   = 8,
   parameter mbx_pkg::irq_layout_e LAYOUT = mbx_pkg::LAYOUT_SHARED_EN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_W-1:0] ev,
   input  logic [EV_W-1:0] wbits,
   input  logic            sts_wr,
   input  logic            en_wr,
   input  logic            clr_wr,
   output logic [EV_W-1:0] sts,
   output logic [EV_W-1:0] en,
   output logic            irq
);

   logic [EV_W-1:0] clr_mask;

   assign clr_mask = sts_wr ? wbits : '0;

   // events override a same-cycle write-one-to-clear
   always_ff @(posedge clk) begin
      if (!rst_n) sts <= '0;
      else        sts <= (sts & ~clr_mask) | ev;
   end

   if (LAYOUT == mbx_pkg::LAYOUT_SHARED_EN) begin : g_shared
      always_ff @(posedge clk) begin
         if (!rst_n)      en <= '0;
         else if (en_wr)  en <= wbits;
         else if (clr_wr) en <= en & ~wbits;
      end

      // R10: whole-mask replacement
      a_r10_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
         en_wr |=> (en == $past(wbits)));
   end else begin : g_split
      always_ff @(posedge clk) begin
         if (!rst_n)      en <= '0;
         else if (en_wr)  en <= en | wbits;
         else if (clr_wr) en <= en & ~wbits;
      end

      // R11: set register only adds bits
      a_r11_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
         en_wr |=> ((en & $past(wbits)) == $past(wbits)));

      // R11: set register keeps bits already enabled
      a_r11_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         en_wr |=> ((en & $past(en)) == $past(en)));

      // R11: clear register removes the written bits
      a_r11_clr_removes: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && !en_wr) |=> ((en & $past(wbits)) == '0));
   end

   assign irq = |(sts & en);

   // R7: a present event is latched on the next edge
   a_r7_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((sts & $past(ev)) == $past(ev)));

   // R8: written ones with no event present are cleared
   a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && ((wbits & ~ev) != '0)) |=> ((sts & $past(wbits & ~ev)) == '0));

   // R7: without a clear, status bits are sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_wr |=> ((sts & $past(sts)) == $past(sts)));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int                   NUM_FIFOS  = 4,
   parameter int                   NUM_USERS  = 2,
   parameter int                   FIFO_DEPTH = 4,
   parameter int                   DATA_W     = 32,
   parameter int                   ADDR_W     = 12,
   parameter mbx_pkg::irq_layout_e LAYOUT     = mbx_pkg::LAYOUT_SHARED_EN,
   parameter logic [DATA_W-1:0]    REV_ID     = DATA_W'(32'h0000_0210)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_USERS-1:0] irq
);

   localparam int EV_W   = 2 * NUM_FIFOS;
   localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
   localparam int TOP_OF = mbx_pkg::IRQ_BASE + 16 * NUM_USERS;

   initial begin
      assert (NUM_FIFOS >= 1 && NUM_FIFOS <= mbx_pkg::MAX_FIFOS)
         else $error("ipc_mailbox: NUM_FIFOS out of range");
      assert (NUM_USERS >= 1) else $error("ipc_mailbox: NUM_USERS must be positive");
      assert (EV_W <= DATA_W) else $error("ipc_mailbox: event bits exceed data width");
      assert (TOP_OF <= (1 << ADDR_W)) else $error("ipc_mailbox: ADDR_W too narrow");
   end

   logic                 rev_hit;
   logic [NUM_FIFOS-1:0] msg_hit, full_hit, cnt_hit;
   logic [NUM_USERS-1:0] sts_hit, en_hit, clr_hit;

   mbx_decode #(
      .NUM_FIFOS (NUM_FIFOS),
      .NUM_USERS (NUM_USERS),
      .ADDR_W    (ADDR_W),
      .LAYOUT    (LAYOUT)
   ) i_decode (
      .addr     (bus_addr),
      .rev_hit  (rev_hit),
      .msg_hit  (msg_hit),
      .full_hit (full_hit),
      .cnt_hit  (cnt_hit),
      .sts_hit  (sts_hit),
      .en_hit   (en_hit),
      .clr_hit  (clr_hit)
   );

   logic [DATA_W-1:0]    head_w [NUM_FIFOS];
   logic [CNT_W-1:0]     cnt_w  [NUM_FIFOS];
   logic [NUM_FIFOS-1:0] full_w, empty_w;
   logic [EV_W-1:0]      ev;

   for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
      mbx_fifo #(
         .DATA_W (DATA_W),
         .DEPTH  (FIFO_DEPTH)
      ) i_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (bus_wr && msg_hit[m]),
         .pop   (bus_rd && msg_hit[m]),
         .wdata (bus_wdata),
         .head  (head_w[m]),
         .count (cnt_w[m]),
         .full  (full_w[m]),
         .empty (empty_w[m])
      );
      assign ev[2*m]   = !empty_w[m];
      assign ev[2*m+1] = !full_w[m];
   end

   logic [EV_W-1:0] sts_w [NUM_USERS];
   logic [EV_W-1:0] en_w  [NUM_USERS];

   for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
      mbx_user_irq #(
         .EV_W   (EV_W),
         .LAYOUT (LAYOUT)
      ) i_user (
         .clk    (clk),
         .rst_n  (rst_n),
         .ev     (ev),
         .wbits  (bus_wdata[EV_W-1:0]),
         .sts_wr (bus_wr && sts_hit[u]),
         .en_wr  (bus_wr && en_hit[u]),
         .clr_wr (bus_wr && clr_hit[u]),
         .sts    (sts_w[u]),
         .en     (en_w[u]),
         .irq    (irq[u])
      );
   end

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (rev_hit) rd_val = REV_ID;
      for (int m = 0; m < NUM_FIFOS; m++) begin
         if (msg_hit[m])  rd_val = head_w[m];
         if (full_hit[m]) rd_val = DATA_W'(full_w[m]);
         if (cnt_hit[m])  rd_val = DATA_W'(cnt_w[m]);
      end
      for (int u = 0; u < NUM_USERS; u++) begin
         if (sts_hit[u])              rd_val = DATA_W'(sts_w[u]);
         if (en_hit[u] || clr_hit[u]) rd_val = DATA_W'(en_w[u]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end

   // R12: read data is held between read strobes
   a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R12: at most one register answers an address
   a_r12_decode_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rev_hit, msg_hit, full_hit, cnt_hit, sts_hit, en_hit, clr_hit}));

   // R1: the revision read returns the constant
   a_r1_revision: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && rev_hit) |=> (bus_rdata == REV_ID));

endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

   localparam int NF  = 4;
   localparam int NU  = 2;
   localparam int DEP = 4;
   localparam logic [31:0] REV = 32'h0000_0210;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [11:0]   addr [2];
   logic          wr   [2];
   logic          rd   [2];
   logic [31:0]   wd   [2];
   logic [31:0]   rdat [2];
   logic [NU-1:0] irqv [2];

   ipc_mailbox #(.NUM_FIFOS(NF), .NUM_USERS(NU), .FIFO_DEPTH(DEP),
                 .LAYOUT(mbx_pkg::LAYOUT_SHARED_EN), .REV_ID(REV)) i_ipc_mailbox (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr[0]), .bus_wr(wr[0]), .bus_rd(rd[0]),
      .bus_wdata(wd[0]), .bus_rdata(rdat[0]), .irq(irqv[0]));

   ipc_mailbox #(.NUM_FIFOS(NF), .NUM_USERS(NU), .FIFO_DEPTH(DEP),
                 .LAYOUT(mbx_pkg::LAYOUT_SPLIT_EN), .REV_ID(REV)) i_ipc_mailbox_split (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr[1]), .bus_wr(wr[1]), .bus_rd(rd[1]),
      .bus_wdata(wd[1]), .bus_rdata(rdat[1]), .irq(irqv[1]));

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bw(input int s, input int a, input logic [31:0] d);
      addr[s] = 12'(a);
      wd[s]   = d;
      wr[s]   = 1'b1;
      @(negedge clk);
      wr[s]   = 1'b0;
   endtask

   task automatic br(input int s, input int a, output logic [31:0] d);
      addr[s] = 12'(a);
      rd[s]   = 1'b1;
      @(negedge clk);
      rd[s]   = 1'b0;
      d       = rdat[s];
   endtask

   function automatic int a_msg(input int m);  return 'h040 + 4 * m; endfunction
   function automatic int a_full(input int m); return 'h080 + 4 * m; endfunction
   function automatic int a_cnt(input int m);  return 'h0C0 + 4 * m; endfunction
   function automatic int a_sts(input int s, input int u);
      return (s == 0) ? 'h100 + 8 * u : 'h104 + 16 * u;
   endfunction
   function automatic int a_en(input int s, input int u);
      return (s == 0) ? 'h104 + 8 * u : 'h108 + 16 * u;
   endfunction
   function automatic int a_clr(input int u); return 'h10C + 16 * u; endfunction
   function automatic logic [31:0] pat(input int m, input int k);
      return 32'hC0DE_0000 | 32'(m << 8) | 32'(k);
   endfunction

   task automatic run(input int s);
      logic [31:0] v;
      string lay;
      lay = (s == 0) ? "R10" : "R11";
      // reset state
      chk("R12 irq after reset", 32'(irqv[s]), 32'h0);
      br(s, 'h000, v); chk("R1 revision", v, REV);
      br(s, 'h1F0, v); chk("R12 unmapped", v, 32'h0);
      for (int m = 0; m < NF; m++) begin
         br(s, a_cnt(m), v);  chk("R6 count after reset", v, 32'h0);
         br(s, a_full(m), v); chk("R5 full after reset", v, 32'h0);
      end
      // FIFO sweep: overfill by one, drain, underflow
      for (int m = 0; m < NF; m++) begin
         for (int k = 0; k <= DEP; k++) bw(s, a_msg(m), pat(m, k));
         br(s, a_full(m), v); chk("R5 full flag", v, 32'h1);
         br(s, a_cnt(m), v);  chk("R3 count at full", v, 32'(DEP));
         for (int k = 0; k < DEP; k++) begin
            br(s, a_msg(m), v); chk("R2 pop order", v, pat(m, k));
            if (k == 0) begin
               br(s, a_cnt(m), v); chk("R6 count after one pop", v, 32'(DEP - 1));
               br(s, a_full(m), v); chk("R5 not full", v, 32'h0);
            end
         end
         br(s, a_msg(m), v); chk("R4 empty read", v, 32'h0);
         br(s, a_cnt(m), v); chk("R4 count stays zero", v, 32'h0);
      end
      // status events
      for (int u = 0; u < NU; u++) bw(s, a_sts(s, u), 32'hFF);
      idle(1);
      for (int u = 0; u < NU; u++) begin
         br(s, a_sts(s, u), v); chk("R7 not-full bits", v, 32'hAA);
      end
      bw(s, a_msg(2), 32'h1234_5678);
      idle(1);
      br(s, a_sts(s, 1), v); chk("R7 new-message bit", v, 32'hBA);
      bw(s, a_sts(s, 1), 32'h10);
      br(s, a_sts(s, 1), v); chk("R8 set wins over clear", v, 32'hBA);
      bw(s, a_sts(s, 1), 32'h02);
      br(s, a_sts(s, 1), v); chk("R8 not-full re-asserts", v, 32'hBA);
      br(s, a_msg(2), v); chk("R2 single word", v, 32'h1234_5678);
      idle(1);
      bw(s, a_sts(s, 1), 32'h10);
      br(s, a_sts(s, 1), v); chk("R8 clear after drain", v, 32'hAA);
      br(s, a_sts(s, 0), v); chk("R7 other user sticky", v, 32'hBA);
      for (int k = 0; k < DEP; k++) bw(s, a_msg(3), pat(3, k));
      idle(1);
      bw(s, a_sts(s, 0), 32'h80);
      br(s, a_sts(s, 0), v); chk("R8 not-full clear when full", v, 32'h7A);
      // interrupt routing
      chk("R9 no enable no irq", 32'(irqv[s]), 32'h0);
      bw(s, a_en(s, 0), 32'h40);
      chk("R9 irq user0", 32'(irqv[s]), 32'h1);
      br(s, a_en(s, 0), v); chk({lay, " enable read"}, v, 32'h40);
      bw(s, a_en(s, 0), (s == 0) ? 32'h41 : 32'h01);
      br(s, a_en(s, 0), v); chk({lay, " enable add"}, v, 32'h41);
      if (s == 1) begin
         br(s, a_clr(0), v); chk("R11 clear reg reads mask", v, 32'h41);
         bw(s, a_clr(0), 32'h40);
      end else begin
         bw(s, a_en(s, 0), 32'h01);
      end
      br(s, a_en(s, 0), v); chk({lay, " enable remove"}, v, 32'h01);
      chk("R9 masked off", 32'(irqv[s]), 32'h0);
      bw(s, a_msg(0), 32'hAB);
      idle(1);
      chk("R9 new message irq", 32'(irqv[s]), 32'h1);
      bw(s, a_en(s, 1), 32'h02);
      chk("R9 both users", 32'(irqv[s]), 32'h3);
   endtask

   initial begin
      for (int s = 0; s < 2; s++) begin
         addr[s] = '0; wr[s] = 1'b0; rd[s] = 1'b0; wd[s] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(0);
      run(1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule